// File: doc/BRIEF.md
# Transactional Response Failure Classifier

This block sits on the memory response path of a load/store unit running hardware transactions. Each response beat carries four things: whether the access was a read or a write, whether it belongs to a transaction and under which transaction ID, and whether the cache hierarchy reported that the transaction failed (with a 2-bit return code). The beat also carries the squashed flag and transaction ID of the instruction that issued the access.

The classifier turns each beat into a verdict. A failure on a read becomes an architectural transaction-failure fault, with an abort cause and the instruction's transaction ID. A failure on a write is dropped. A code the block cannot map raises an error. A response whose transaction ID disagrees with a live instruction's ID raises a consistency error. When the response completes a multi-part read, the failure indication is also passed on for the main request, so that writeback sees it.

Classification is combinational. A single registered output stage sits behind it, with a valid/ready handshake on both sides, so each verdict appears one cycle after its beat is accepted.

Top module: `txf_classifier`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat accepted on a rising edge (`in_valid` and `in_ready` both 1) is presented on the outputs from that edge on, with `out_valid` 1. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady and `in_ready` is 0.
- R3: `out_id_err` is 1 exactly when the beat is transactional (`in_txn`=1), its instruction is not squashed, and `in_rsp_id` differs from `in_inst_id`.
- R4: A failure reported on a write (`in_is_write`=1) is ignored: `out_fault`=0, `out_cause`=0, `out_unhandled`=0, `out_main_fail`=0.
- R5: On a read with `in_fail`=1 and code 0 (failure caused by this core), `out_fault`=1 and `out_cause`=1 (size).
- R6: On a read with `in_fail`=1, code 1 (failure caused remotely) gives `out_cause`=2 (memory), and code 2 (any other failure) gives `out_cause`=3 (other). Both set `out_fault`=1.
- R7: On a read with `in_fail`=1 and code 3 (reserved), `out_unhandled`=1, `out_fault`=0 and `out_cause`=0.
- R8: When `out_fault`=1, `out_fault_id` equals the issuing instruction's `in_inst_id`. Otherwise `out_fault_id` is 0.
- R9: On a read with `in_fail`=1 and `in_last_part`=1, `out_main_fail`=1 and `out_main_code` equals the failure code. Otherwise both are 0.
- R10: A beat with `in_fail`=0 produces `out_fault`=0, `out_cause`=0 and `out_unhandled`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Response beat present |
| in_ready | output | 1 | Beat accepted when both valid and ready are 1 |
| in_is_write | input | 1 | 1 for a write response, 0 for a read |
| in_txn | input | 1 | Response belongs to a transaction |
| in_rsp_id | input | IDW | Transaction ID carried by the response |
| in_fail | input | 1 | Cache reported a transaction failure |
| in_fail_code | input | 2 | Failure return code: 0 self, 1 remote, 2 other, 3 reserved |
| in_last_part | input | 1 | Response completes a multi-part request |
| in_squashed | input | 1 | Issuing instruction has been squashed |
| in_inst_id | input | IDW | Issuing instruction's transaction ID |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_fault | output | 1 | Transaction-failure fault attached to the instruction |
| out_cause | output | 2 | Abort cause: 0 none, 1 size, 2 memory, 3 other |
| out_fault_id | output | IDW | Transaction ID carried by the fault |
| out_id_err | output | 1 | Response and instruction IDs disagree |
| out_unhandled | output | 1 | Failure code could not be mapped |
| out_main_fail | output | 1 | Failure copied to the main request |
| out_main_code | output | 2 | Failure code copied to the main request |

## Verification
The bench aims at write responses that carry a failure. A design that does not gate on direction would raise a fault there, or flag the reserved code as unhandled. It runs every code on reads, including the reserved one. A design with a mis-ordered decode would return the wrong cause, or fault where it should report an unhandled code. It sets up ID mismatches on squashed instructions and on non-transactional beats, where a careless check would raise false errors. It also stalls the consumer for several cycles while new beats are offered, which catches a stage that drops its verdict or overwrites it.

// File: rtl/txf_pkg.sv
// Shared encodings for the transactional response failure classifier.
package txf_pkg;

    // Failure return codes reported by the cache hierarchy.
    typedef enum logic [1:0] {
        CODE_SELF   = 2'd0,
        CODE_REMOTE = 2'd1,
        CODE_OTHER  = 2'd2,
        CODE_RSVD   = 2'd3
    } fail_code_e;

    // Architectural abort causes attached to a fault.
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_SIZE   = 2'd1,
        CAUSE_MEMORY = 2'd2,
        CAUSE_OTHER  = 2'd3
    } abort_cause_e;

    // Verdict of the failure-code decode for one beat.
    typedef struct packed {
        logic         fault;
        abort_cause_e cause;
        logic         unhandled;
        logic         main_fail;
        logic [1:0]   main_code;
    } verdict_t;

endpackage

// File: rtl/txf_code_map.sv
// Maps a cache failure report on one response beat to an abort verdict.
// Assumes: purely combinational; write-side failures are dropped.
module txf_code_map
    import txf_pkg::*;
(
    input  logic       is_write,
    input  logic       fail,
    input  logic [1:0] code,
    input  logic       last_part,
    output verdict_t   verdict
);

    logic read_fail;

    // A failure only matters when it arrives on a read.
    always_comb read_fail = fail & ~is_write;

    // Decode the return code into a cause or an unhandled error.
    always_comb begin
        verdict           = '0;
        verdict.cause     = CAUSE_NONE;
        if (read_fail) begin
            unique case (fail_code_e'(code))
                CODE_SELF:   begin verdict.fault = 1'b1; verdict.cause = CAUSE_SIZE;   end
                CODE_REMOTE: begin verdict.fault = 1'b1; verdict.cause = CAUSE_MEMORY; end
                CODE_OTHER:  begin verdict.fault = 1'b1; verdict.cause = CAUSE_OTHER;  end
                default:     verdict.unhandled = 1'b1;
            endcase
            if (last_part) begin
                verdict.main_fail = 1'b1;
                verdict.main_code = code;
            end
        end
    end

endmodule

// File: rtl/txf_id_check.sv
// Checks that a transactional response belongs to the issuing instruction.
// Assumes: squashed instructions and non-transactional beats are exempt.
module txf_id_check #(
    parameter int IDW = 16
) (
    input  logic           txn,
    input  logic           squashed,
    input  logic [IDW-1:0] rsp_id,
    input  logic [IDW-1:0] inst_id,
    output logic           mismatch
);

    // Flag a live transactional beat whose IDs disagree.
    always_comb mismatch = txn & ~squashed & (rsp_id != inst_id);

endmodule

// File: rtl/txf_out_stage.sv
// One-entry registered output stage with valid/ready on both sides.
// Assumes: a new beat may enter in the same cycle the held one leaves.
module txf_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    // The slot is free when empty or when it drains this cycle.
    always_comb in_ready = ~out_valid | out_ready;

    // Load the slot on each edge it is free; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

endmodule

// File: rtl/txf_classifier.sv
// Top: classifies memory responses for transactional failures and
// registers the verdict behind a valid/ready handshake.
// Assumes: one beat per cycle at most; verdict latency is one cycle.
module txf_classifier
    import txf_pkg::*;
#(
    parameter int IDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic           in_is_write,
    input  logic           in_txn,
    input  logic [IDW-1:0] in_rsp_id,
    input  logic           in_fail,
    input  logic [1:0]     in_fail_code,
    input  logic           in_last_part,
    input  logic           in_squashed,
    input  logic [IDW-1:0] in_inst_id,
    output logic           out_valid,
    input  logic           out_ready,
    output logic           out_fault,
    output logic [1:0]     out_cause,
    output logic [IDW-1:0] out_fault_id,
    output logic           out_id_err,
    output logic           out_unhandled,
    output logic           out_main_fail,
    output logic [1:0]     out_main_code
);

    localparam int PW = IDW + 8;

    verdict_t       verdict;
    logic           id_err;
    logic [IDW-1:0] fault_id;
    logic [PW-1:0]  pack_in;
    logic [PW-1:0]  pack_out;

    txf_code_map u_map (
        .is_write  (in_is_write),
        .fail      (in_fail),
        .code      (in_fail_code),
        .last_part (in_last_part),
        .verdict   (verdict)
    );

    txf_id_check #(.IDW(IDW)) u_idchk (
        .txn      (in_txn),
        .squashed (in_squashed),
        .rsp_id   (in_rsp_id),
        .inst_id  (in_inst_id),
        .mismatch (id_err)
    );

    // The fault carries the instruction's transaction ID, else zero.
    always_comb fault_id = verdict.fault ? in_inst_id : '0;

    // Pack the verdict for the register stage.
    always_comb pack_in = {verdict.main_code, verdict.main_fail, verdict.unhandled,
                           id_err, fault_id, verdict.cause, verdict.fault};

    txf_out_stage #(.W(PW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (pack_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (pack_out)
    );

    // Unpack the registered verdict onto the ports.
    always_comb begin
        out_fault     = pack_out[0];
        out_cause     = pack_out[2:1];
        out_fault_id  = pack_out[IDW+2:3];
        out_id_err    = pack_out[IDW+3];
        out_unhandled = pack_out[IDW+4];
        out_main_fail = pack_out[IDW+5];
        out_main_code = pack_out[IDW+7:IDW+6];
    end

endmodule

// File: rtl/txf_classifier_chk.sv
// Checker bound to txf_classifier: relates accepted beats to the verdict
// presented on the following cycle, and the hold behaviour under stall.
module txf_classifier_chk #(
    parameter int IDW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           in_is_write,
    input logic           in_txn,
    input logic [IDW-1:0] in_rsp_id,
    input logic           in_fail,
    input logic [1:0]     in_fail_code,
    input logic           in_last_part,
    input logic           in_squashed,
    input logic [IDW-1:0] in_inst_id,
    input logic           out_valid,
    input logic           out_ready,
    input logic           out_fault,
    input logic [1:0]     out_cause,
    input logic [IDW-1:0] out_fault_id,
    input logic           out_id_err,
    input logic           out_unhandled,
    input logic           out_main_fail,
    input logic [1:0]     out_main_code
);

    logic acc;
    logic rd_fail;
    always_comb acc = in_valid & in_ready;
    always_comb rd_fail = acc & ~in_is_write & in_fail;

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid) else $error("accept"); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable({out_fault, out_cause, out_fault_id,
            out_id_err, out_unhandled, out_main_fail, out_main_code})) else $error("hold"); // R2
    AST_ID_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_txn && !in_squashed && (in_rsp_id != in_inst_id) |=> out_id_err)
        else $error("id"); // R3
    AST_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_is_write |=> !out_fault && !out_unhandled && out_cause == 2'd0
            && !out_main_fail) else $error("write"); // R4
    AST_SELF_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fail && in_fail_code == 2'd0 |=> out_fault && out_cause == 2'd1)
        else $error("size"); // R5
    AST_REMOTE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fail && in_fail_code == 2'd1 |=> out_fault && out_cause == 2'd2)
        else $error("memory"); // R6
    AST_RSVD_UNHANDLED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fail && in_fail_code == 2'd3 |=> out_unhandled && !out_fault)
        else $error("unhandled"); // R7
    AST_FAULT_ID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fail && in_fail_code != 2'd3 |=> out_fault_id == $past(in_inst_id))
        else $error("fault id"); // R8
    AST_MAIN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fail && in_last_part |=> out_main_fail && out_main_code == $past(in_fail_code))
        else $error("main copy"); // R9
    AST_NO_FAIL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !in_fail |=> !out_fault && !out_unhandled && out_cause == 2'd0)
        else $error("clean"); // R10

endmodule

bind txf_classifier txf_classifier_chk #(.IDW(IDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_write(in_is_write), .in_txn(in_txn), .in_rsp_id(in_rsp_id),
    .in_fail(in_fail), .in_fail_code(in_fail_code), .in_last_part(in_last_part),
    .in_squashed(in_squashed), .in_inst_id(in_inst_id), .out_valid(out_valid),
    .out_ready(out_ready), .out_fault(out_fault), .out_cause(out_cause),
    .out_fault_id(out_fault_id), .out_id_err(out_id_err), .out_unhandled(out_unhandled),
    .out_main_fail(out_main_fail), .out_main_code(out_main_code)
);

// File: tb/txf_classifier_test.sv
`timescale 1ns/1ps
module txf_classifier_test;

    localparam int IDW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0, in_ready;
    logic           in_is_write = 1'b0, in_txn = 1'b0, in_fail = 1'b0;
    logic           in_last_part = 1'b0, in_squashed = 1'b0;
    logic [1:0]     in_fail_code = 2'd0;
    logic [IDW-1:0] in_rsp_id = '0, in_inst_id = '0;
    logic           out_valid, out_ready = 1'b1;
    logic           out_fault, out_id_err, out_unhandled, out_main_fail;
    logic [1:0]     out_cause, out_main_code;
    logic [IDW-1:0] out_fault_id;

    typedef struct {
        logic           fault;
        logic [1:0]     cause;
        logic [IDW-1:0] fid;
        logic           id_err;
        logic           unh;
        logic           mfail;
        logic [1:0]     mcode;
        string          tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;
    int unsigned lfsr = 32'h1234_5678;

    always #2.5 clk = ~clk;

    txf_classifier #(.IDW(IDW)) uut (.*);

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    function automatic exp_t model(input logic w, input logic txn, input logic [IDW-1:0] rid,
        input logic f, input logic [1:0] c, input logic last, input logic sq,
        input logic [IDW-1:0] iid);
        exp_t e;
        e.id_err = txn && !sq && (rid != iid);     // R3
        e.fault = 0; e.cause = 0; e.unh = 0; e.mfail = 0; e.mcode = 0; e.fid = 0;
        if (!f)      e.tag = "R10";
        else if (w)  e.tag = "R4";
        else begin
            if (c == 2'd3) begin e.unh = 1; e.tag = "R7"; end
            else begin
                e.fault = 1;
                e.cause = (c == 2'd0) ? 2'd1 : (c == 2'd1) ? 2'd2 : 2'd3;
                e.tag = (c == 2'd0) ? "R5" : "R6";
                e.fid = iid;                       // R8
            end
            if (last) begin e.mfail = 1; e.mcode = c; end  // R9
        end
        return e;
    endfunction

    // One cycle: drive, then compare what the coming edge hands over.
    task automatic step(input logic v, input logic w, input logic txn, input logic [IDW-1:0] rid,
        input logic f, input logic [1:0] c, input logic last, input logic sq,
        input logic [IDW-1:0] iid, input logic ordy);
        @(negedge clk);
        in_valid = v; in_is_write = w; in_txn = txn; in_rsp_id = rid; in_fail = f;
        in_fail_code = c; in_last_part = last; in_squashed = sq; in_inst_id = iid;
        out_ready = ordy;
        #1;
        check("R2", "out_valid", 32'(out_valid), 32'(exp_q.size() > 0));
        check("R2", "in_ready", 32'(in_ready), 32'(exp_q.size() == 0 || ordy));
        if (out_valid && exp_q.size() > 0) begin
            exp_t e = exp_q[0];
            check(e.tag, "fault", 32'(out_fault), 32'(e.fault));
            check(e.tag, "cause", 32'(out_cause), 32'(e.cause));
            check("R7", "unhandled", 32'(out_unhandled), 32'(e.unh));
            check("R8", "fault_id", 32'(out_fault_id), 32'(e.fid));
            check("R3", "id_err", 32'(out_id_err), 32'(e.id_err));
            check("R9", "main_fail", 32'(out_main_fail), 32'(e.mfail));
            check("R9", "main_code", 32'(out_main_code), 32'(e.mcode));
        end
        if (out_valid && ordy && exp_q.size() > 0) void'(exp_q.pop_front());
        if (v && in_ready) exp_q.push_back(model(w, txn, rid, f, c, last, sq, iid));
    endtask

    function automatic int unsigned rnd();
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        return lfsr >> 8;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "reset out_valid", 32'(out_valid), 32'd0);
        check("R1", "reset in_ready", 32'(in_ready), 32'd1);
        @(negedge clk) rst_n = 1'b1;
        // R10: clean read, transactional, matching IDs
        step(1, 0, 1, 16'h11, 0, 2'd0, 0, 0, 16'h11, 1);
        // R5: self failure on read, last part (R9)
        step(1, 0, 1, 16'h22, 1, 2'd0, 1, 0, 16'h22, 1);
        // R6: remote and other on reads
        step(1, 0, 1, 16'h33, 1, 2'd1, 0, 0, 16'h33, 1);
        step(1, 0, 1, 16'h34, 1, 2'd2, 1, 0, 16'h34, 1);
        // R7: reserved code on read
        step(1, 0, 1, 16'h35, 1, 2'd3, 1, 0, 16'h35, 1);
        // R4: failures on writes ignored, every code
        for (int k = 0; k < 4; k++) step(1, 1, 1, 16'h40, 1, 2'(k), 1, 0, 16'h40, 1);
        // R3: mismatch live, squashed, non-transactional
        step(1, 0, 1, 16'h50, 0, 2'd0, 0, 0, 16'h51, 1);
        step(1, 0, 1, 16'h50, 0, 2'd0, 0, 1, 16'h51, 1);
        step(1, 0, 0, 16'h50, 1, 2'd1, 0, 0, 16'h51, 1);
        // R2: stall consumer while new beats are offered
        step(1, 0, 1, 16'h60, 1, 2'd2, 0, 0, 16'h60, 0);
        step(1, 0, 1, 16'h61, 1, 2'd0, 0, 0, 16'h61, 0);
        step(1, 0, 1, 16'h62, 1, 2'd1, 1, 0, 16'h62, 0);
        step(1, 0, 1, 16'h63, 1, 2'd1, 1, 0, 16'h63, 1);
        step(0, 0, 0, 16'h0, 0, 2'd0, 0, 0, 16'h0, 1);
        // Pseudorandom mix
        for (int i = 0; i < 400; i++) begin
            int unsigned r = rnd();
            logic [IDW-1:0] iid = IDW'(rnd());
            logic [IDW-1:0] rid = r[3] ? iid : IDW'(rnd());
            step(r[0], r[1], r[2], rid, r[4], r[6:5], r[7], r[8], iid, r[9] | r[10]);
        end
        step(0, 0, 0, 16'h0, 0, 2'd0, 0, 0, 16'h0, 1);
        step(0, 0, 0, 16'h0, 0, 2'd0, 0, 0, 16'h0, 1);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule